// File: doc/BRIEF.md
# DMA Completion Interrupt Register

This block holds the interrupt control word of a multi-channel DMA engine. It is one 32-bit register that mixes three kinds of field. Some bits are plain read/write configuration. Per-channel done flags are set by hardware and cleared when software writes a one to them. A master flag is computed by hardware and cannot be written. Each channel engine delivers a one-cycle completion pulse. When that channel's enable bit is set, the pulse latches the channel's flag. A bus-error input latches the error bit.

The master flag is on while the global enable is on and any done flag is pending, or while the error bit is on. A small state machine follows the master flag. It has three states: `MST_CLEAR` (master off), `MST_FIRE` (master has just turned on) and `MST_HELD` (master still on). Its transitions are:
- **raise**: `MST_CLEAR` to `MST_FIRE`, when the condition becomes true.
- **hold**: `MST_FIRE` to `MST_HELD`, or `MST_HELD` to `MST_HELD`, while the condition stays true.
- **drop**: `MST_FIRE` or `MST_HELD` to `MST_CLEAR`, when the condition goes false.
- **idle**: `MST_CLEAR` to `MST_CLEAR`, while the condition stays false.

The one-cycle request to the system interrupt controller is issued only in `MST_FIRE`. Software must therefore clear the master condition before a new request can be issued.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00000000 and `irq_pulse` is low.
- R2: A write stores `wr_data & 0x00FF803F` into the plain fields. These are bits 5:0, bit 15 (error), bits 22:16 (channel enables, channel n at bit 16+n) and bit 23 (global enable). Bits 14:6 always read 0. Writing bit 31 has no effect on it.
- R3: A write with a 1 in bit 24+n clears done flag n. A 0 in that position leaves the flag unchanged.
- R4: A one-cycle pulse on `done[n]` sets flag bit 24+n only if enable bit 16+n is 1 in the register at that clock edge. The enable value used is the one held before any write in the same cycle.
- R5: When a completion pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Bit 31 reads 1 exactly when (bit 23 and any of bits 30:24) or bit 15 is set. The evaluation is done on the register contents after the current edge's update.
- R7: When that condition no longer holds, bit 31 reads 0 from the next cycle on, including after a write that removes it.
- R8: `irq_pulse` is high for one cycle, in the first cycle bit 31 reads 1 after reading 0. No further pulse is issued while bit 31 stays 1.
- R9: A pulse on `bus_err_in` sets bit 15. If the same cycle carries a write with bit 15 = 0, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| done | input | NCH (7) | Per-channel completion pulses |
| bus_err_in | input | 1 | Bus error pulse |
| rd_data | output | 32 | Register readback |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions: a completion pulse arriving with a write that clears the same flag, and a completion pulse arriving with a write that changes the enables. Both need the pulse and the write strobe driven in the same cycle. The bench does this with a single step task that can drive all inputs in one cycle. It also sweeps every channel with its enable on and off, holds the master flag on while further pulses arrive to show that no second request is issued, and then drops and re-raises the master flag.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int REG_W    = 32;
    localparam int LOW_W    = 6;
    localparam int BERR_BIT = 15;
    localparam int EN_LSB   = 16;
    localparam int GIE_BIT  = 23;
    localparam int FLG_LSB  = 24;
    localparam int MST_BIT  = 31;

    typedef enum logic [1:0] {
        MST_CLEAR = 2'd0,
        MST_FIRE  = 2'd1,
        MST_HELD  = 2'd2
    } mst_state_e;
endpackage

// File: rtl/dma_irq_fields.sv
module dma_irq_fields
    import dma_irq_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [NCH-1:0]   done,
    input  logic             bus_err_in,
    output logic [LOW_W-1:0] low_q,
    output logic             berr_q,
    output logic [NCH-1:0]   en_q,
    output logic             gie_q,
    output logic [NCH-1:0]   flags_q,
    output logic             cond_next
);
    logic [LOW_W-1:0] low_n;
    logic             berr_n;
    logic [NCH-1:0]   en_n;
    logic             gie_n;
    logic [NCH-1:0]   flags_n;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[BERR_BIT-1:LOW_W], wr_data[MST_BIT]};

    always_comb begin
        low_n  = wr_en ? wr_data[LOW_W-1:0]      : low_q;
        en_n   = wr_en ? wr_data[EN_LSB +: NCH]  : en_q;
        gie_n  = wr_en ? wr_data[GIE_BIT]        : gie_q;
        berr_n = (wr_en ? wr_data[BERR_BIT] : berr_q) | bus_err_in;
    end

    // Per-channel flag: completion set has priority over a clearing write.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_flag
        logic clr;
        logic set;
        assign clr = wr_en & wr_data[FLG_LSB + ch];
        assign set = done[ch] & en_q[ch];
        assign flags_n[ch] = set | (flags_q[ch] & ~clr);
    end

    assign cond_next = (gie_n & (|flags_n)) | berr_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= '0;
            berr_q  <= 1'b0;
            en_q    <= '0;
            gie_q   <= 1'b0;
            flags_q <= '0;
        end else begin
            low_q   <= low_n;
            berr_q  <= berr_n;
            en_q    <= en_n;
            gie_q   <= gie_n;
            flags_q <= flags_n;
        end
    end
endmodule

// File: rtl/dma_irq_master_fsm.sv
module dma_irq_master_fsm
    import dma_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_next,
    output logic master,
    output logic irq_pulse
);
    mst_state_e state_q;
    mst_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            MST_CLEAR: state_n = cond_next ? MST_FIRE : MST_CLEAR;
            MST_FIRE:  state_n = cond_next ? MST_HELD : MST_CLEAR;
            MST_HELD:  state_n = cond_next ? MST_HELD : MST_CLEAR;
            default:   state_n = MST_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MST_CLEAR;
        else        state_q <= state_n;
    end

    always_comb begin
        master    = 1'b0;
        irq_pulse = 1'b0;
        unique case (state_q)
            MST_CLEAR: begin
                master    = 1'b0;
                irq_pulse = 1'b0;
            end
            MST_FIRE: begin
                master    = 1'b1;
                irq_pulse = 1'b1;
            end
            MST_HELD: begin
                master    = 1'b1;
                irq_pulse = 1'b0;
            end
            default: begin
                master    = 1'b0;
                irq_pulse = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic [NCH-1:0]   done,
    input  logic             bus_err_in,
    output logic [31:0]      rd_data,
    output logic             irq_pulse
);
    localparam int FLG_MSB = FLG_LSB + NCH - 1;

    logic [LOW_W-1:0] low_q;
    logic             berr_q;
    logic [NCH-1:0]   en_q;
    logic             gie_q;
    logic [NCH-1:0]   flags_q;
    logic             cond_next;
    logic             master;

    initial begin
        if (FLG_MSB >= MST_BIT) $error("NCH too large for register layout");
    end

    dma_irq_fields #(.NCH(NCH)) u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .done       (done),
        .bus_err_in (bus_err_in),
        .low_q      (low_q),
        .berr_q     (berr_q),
        .en_q       (en_q),
        .gie_q      (gie_q),
        .flags_q    (flags_q),
        .cond_next  (cond_next)
    );

    dma_irq_master_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_next (cond_next),
        .master    (master),
        .irq_pulse (irq_pulse)
    );

    always_comb begin
        rd_data                   = '0;
        rd_data[LOW_W-1:0]        = low_q;
        rd_data[BERR_BIT]         = berr_q;
        rd_data[EN_LSB +: NCH]    = en_q;
        rd_data[GIE_BIT]          = gie_q;
        rd_data[FLG_LSB +: NCH]   = flags_q;
        rd_data[MST_BIT]          = master;
    end
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [6:0]  done,
    input logic [31:0] rd_data,
    input logic        irq_pulse
);
    // R8
    irq_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> rd_data[31]);

    // R8
    irq_only_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> !$past(rd_data[31]));

    // R8
    rise_gives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[31]) |-> irq_pulse);

    // R6
    master_matches_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[31] == ((rd_data[23] && (|rd_data[30:24])) || rd_data[15]));

    // R2
    gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[14:6] == 9'd0);

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[24] && !done[0]) |=> !rd_data[24]);
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .done      (done),
    .rd_data   (rd_data),
    .irq_pulse (irq_pulse)
);

// File: tb/tb_dma_irq_ctrl.sv
`timescale 1ns/1ps
module tb_dma_irq_ctrl;
    localparam int NCH = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [NCH-1:0] done = '0;
    logic        bus_err_in = 1'b0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_reg = '0;
    logic        exp_irq = 1'b0;

    always #5 clk = ~clk;

    dma_irq_ctrl #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .done(done), .bus_err_in(bus_err_in), .rd_data(rd_data),
        .irq_pulse(irq_pulse)
    );

    task automatic check(input string req);
        n_chk++;
        if (rd_data !== exp_reg || irq_pulse !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: rd_data=%08h irq=%0b expected rd_data=%08h irq=%0b",
                     req, rd_data, irq_pulse, exp_reg, exp_irq);
        end
    endtask

    // One clock: drive inputs, model the expected result, compare after the edge.
    task automatic step(input logic w, input logic [31:0] wd,
                        input logic [6:0] dn, input logic be, input string req);
        logic [31:0] plain;
        logic [6:0]  flg;
        logic        cond;
        @(negedge clk);
        wr_en = w; wr_data = wd; done = dn; bus_err_in = be;
        plain = w ? (wd & 32'h00FF803F) : (exp_reg & 32'h00FF803F);
        if (be) plain[15] = 1'b1;
        flg = (exp_reg[30:24] & ~(w ? wd[30:24] : 7'd0)) | (dn & exp_reg[22:16]);
        cond = (plain[23] && (|flg)) || plain[15];
        exp_irq = cond && !exp_reg[31];
        exp_reg = plain | ({25'd0, flg} << 24) | ({31'd0, cond} << 31);
        @(posedge clk);
        #1;
        wr_en = 1'b0; done = '0; bus_err_in = 1'b0;
        check(req);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: sweep the low plain field, plus gap and master bits that must stay zero
        for (int v = 0; v < 64; v++)
            step(1'b1, 32'h80007FC0 | v, 7'd0, 1'b0, "R2");
        // R2/R9/R8: all-ones write sets error bit, master rises once
        step(1'b1, 32'hFFFFFFFF, 7'd0, 1'b0, "R2_R8");
        step(1'b0, 32'h0, 7'd0, 1'b0, "R8_held");
        // R7: clearing everything drops master
        step(1'b1, 32'h0, 7'd0, 1'b0, "R7");

        for (int ch = 0; ch < NCH; ch++) begin
            for (int en = 0; en < 2; en++) begin
                // R4: only enabled channel latches; all pulses arrive
                step(1'b1, en ? (32'h1 << (16 + ch)) : 32'h0, 7'd0, 1'b0, "R2");
                step(1'b0, 32'h0, 7'h7F, 1'b0, "R4");
                // R6/R8: global enable turns master on if a flag is pending
                step(1'b1, (en ? (32'h1 << (16 + ch)) : 32'h0) | 32'h00800000,
                     7'd0, 1'b0, "R6_R8");
                step(1'b0, 32'h0, 7'h7F, 1'b0, "R8_no_repeat");
                // R5: pulse and clearing write collide
                step(1'b1, (32'h1 << (24 + ch)) | (32'h1 << (16 + ch)) | 32'h00800000,
                     7'h1 << ch, 1'b0, "R5");
                // R3: writing zero to flags leaves them
                step(1'b1, (32'h1 << (16 + ch)) | 32'h00800000, 7'd0, 1'b0, "R3_keep");
                // R3/R7: write-one clears, master drops
                step(1'b1, 32'h7F000000 | (32'h1 << (16 + ch)) | 32'h00800000,
                     7'd0, 1'b0, "R3_R7");
                step(1'b1, 32'h0, 7'd0, 1'b0, "R7");
            end
        end

        // R4: enable written in the same cycle as the pulse does not count yet
        step(1'b1, 32'h00810000, 7'h01, 1'b0, "R4_same_cycle");
        // R9: error input raises master, beats a same-cycle write of zero
        step(1'b1, 32'h0, 7'd0, 1'b1, "R9");
        step(1'b0, 32'h0, 7'd0, 1'b1, "R9_held");
        step(1'b1, 32'h0, 7'd0, 1'b0, "R7");
        step(1'b0, 32'h0, 7'd0, 1'b1, "R9_R8_again");
        step(1'b1, 32'h0, 7'd0, 1'b0, "R7");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule